// File: doc/BRIEF.md
# Single-Clock First-Word Fall-Through FIFO

This block buffers a stream of data words between a producer and a consumer that run on the same clock. Both sides use a valid/ready handshake in AXI4-Stream style: a word moves whenever valid and ready are high in the same cycle. On the read side the oldest stored word already sits on `out_data` with `out_vld` high, so the consumer needs no read request. It takes the word by raising `out_rdy`.

Words are held in a synchronous RAM array that block RAM can be inferred from. The registered read port of that array is the output stage. The array's behaviour when one address is read and written in the same cycle is a parameter, read-before-write or write-before-read. The fetch scheme never reads the slot being written, so word order is the same in either mode. The depth does not have to be a power of two.

Two fill levels are reported. `wr_level` is the producer's view and counts a word from its acceptance edge. `rd_level` is the consumer's view and counts a word once it can be fetched, which includes the word in the output stage. The full and almost-full flags follow `wr_level`. The empty and almost-empty flags follow `rd_level`. The value of `in_rdy` during reset is a parameter.

Top module: `sync_fwft_fifo`

## Requirements
- R1: While `rd_level` is nonzero, `out_vld` is high and `out_data` holds the oldest unread word. A word is removed only in a cycle where `out_vld` and `out_rdy` are both high. While `out_vld` is high and `out_rdy` is low, `out_data` and `out_vld` stay unchanged.
- R2: Words leave in the order they were accepted, with none lost and none repeated. This holds for both RAM modes (`RAM_MODE` = `RAM_RBW` or `RAM_WBR`).
- R3: A word is accepted at a rising edge where `in_vld` and `in_rdy` are both high and reset is low. Outside the first cycle after reset, `in_rdy` is high exactly when `wr_level` < `DEPTH`. `in_rdy` is registered, so a read in the same cycle as a full FIFO does not open the input in that cycle.
- R4: A word accepted at edge k into an empty FIFO raises `out_vld` after edge k+1.
- R5: `wr_level` equals the number of words accepted minus the number consumed, and it is updated at the acceptance edge. `full` is high exactly when `wr_level` equals `DEPTH`.
- R6: `rd_level` equals `wr_level` minus one when a word was accepted at the previous edge, and equals `wr_level` otherwise. `empty` is high exactly when `rd_level` is 0.
- R7: When `AF_EN` = 1, `almost_full` is high exactly when `wr_level` >= `AF_LVL`. When `AF_EN` = 0, `almost_full` stays low.
- R8: When `AE_EN` = 1, `almost_empty` is high exactly when `rd_level` <= `AE_LVL`. When `AE_EN` = 0, `almost_empty` stays low.
- R9: Reset is synchronous and active high. After a reset edge both levels are 0, `out_vld` and `full` are low, and `empty` is high. `in_rdy` equals `RDY_RST` in the cycle after each reset edge. Words offered while reset is high are not stored.
- R10: The read and write addresses wrap from `DEPTH`-1 to 0, so ordering holds across many fill and drain rounds at a depth that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Word offered by the producer |
| in_vld | input | 1 | Producer has a word |
| in_rdy | output | 1 | FIFO can take a word |
| out_data | output | DATA_W | Oldest stored word |
| out_vld | output | 1 | `out_data` holds a word |
| out_rdy | input | 1 | Consumer takes the word |
| full | output | 1 | `wr_level` equals `DEPTH` |
| almost_full | output | 1 | `wr_level` at or above `AF_LVL` |
| wr_level | output | LVL_W | Fill level as seen by the producer |
| empty | output | 1 | No word visible to the consumer |
| almost_empty | output | 1 | `rd_level` at or below `AE_LVL` |
| rd_level | output | LVL_W | Fill level as seen by the consumer |

## Verification
The assertions assume that reset is held for at least one edge before traffic starts. They assume nothing about the handshake inputs: `in_vld` may drop without a transfer, and `out_rdy` may toggle freely. The stimulus stays inside these limits. It starts with a reset during which valid is held high, and it keeps `in_vld` low in the first cycle after reset so that the two instances, which use different `RDY_RST` values, stay in step. After that, valid and ready are drawn at random with several probability mixes, including a producer that is faster than the consumer, so the FIFO sits at full and at empty many times. A mid-stream reset is applied while the FIFO is partly filled.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Behaviour of the storage array on a same-address read and write
  typedef enum logic {
    RAM_RBW = 1'b0,  // read returns the previous content
    RAM_WBR = 1'b1   // read returns the data being written
  } ram_mode_e;

  // Address width for an array of the given number of entries
  function automatic int addr_bits(input int entries);
    return (entries > 1) ? $clog2(entries) : 1;
  endfunction

  // Counter width able to hold the value 'max_val'
  function automatic int count_bits(input int max_val);
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int                  DATA_W = 8,
  parameter int                  DEPTH  = 12,
  parameter sfifo_pkg::ram_mode_e MODE  = sfifo_pkg::RAM_RBW,
  localparam int                 AW     = sfifo_pkg::addr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // The read register doubles as the output stage; it updates only on re
  generate
    if (MODE == sfifo_pkg::RAM_WBR) begin : g_wbr
      always_ff @(posedge clk) begin
        if (re) begin
          q <= (we && (waddr == raddr)) ? wdata : mem[raddr];
        end
      end
    end else begin : g_rbw
      always_ff @(posedge clk) begin
        if (re) begin
          q <= mem[raddr];
        end
      end
    end
  endgenerate

  assign rdata = q;

endmodule

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
  parameter int  DEPTH = 12,
  localparam int AW    = sfifo_pkg::addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/sfifo_level.sv
module sfifo_level #(
  parameter int DEPTH  = 12,
  parameter int LVL_W  = 4,
  parameter bit EN     = 1'b1,
  parameter int THRESH = 0,
  parameter bit ABOVE  = 1'b1   // 1: flag at or above THRESH, 0: at or below
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [LVL_W-1:0] lvl,
  output logic [LVL_W-1:0] lvl_nxt,
  output logic             flag
);

  logic [LVL_W-1:0] lvl_q;

  always_comb begin
    if (rst) begin
      lvl_nxt = '0;
    end else begin
      lvl_nxt = lvl_q + LVL_W'(inc) - LVL_W'(dec);
    end
  end

  always_ff @(posedge clk) begin
    lvl_q <= lvl_nxt;
  end

  assign lvl = lvl_q;

  generate
    if (EN) begin : g_flag
      localparam logic [LVL_W-1:0] THR = LVL_W'(THRESH);
      logic flag_q;
      if (ABOVE) begin : g_ge
        always_ff @(posedge clk) begin
          flag_q <= (lvl_nxt >= THR);
        end
      end else begin : g_le
        always_ff @(posedge clk) begin
          flag_q <= (lvl_nxt <= THR);
        end
      end
      assign flag = flag_q;
    end else begin : g_noflag
      assign flag = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sfifo_ostage.sv
module sfifo_ostage (
  input  logic clk,
  input  logic rst,
  input  logic mem_avail,  // at least one word waits in the array
  input  logic take,       // consumer ready
  output logic fetch,      // load the read register this cycle
  output logic vld,
  output logic empty
);

  logic vld_q;
  logic empty_q;
  logic vld_nxt;

  assign fetch = mem_avail && (!vld_q || take) && !rst;

  always_comb begin
    if (rst) begin
      vld_nxt = 1'b0;
    end else if (fetch) begin
      vld_nxt = 1'b1;
    end else if (take) begin
      vld_nxt = 1'b0;
    end else begin
      vld_nxt = vld_q;
    end
  end

  always_ff @(posedge clk) begin
    vld_q   <= vld_nxt;
    empty_q <= !vld_nxt;
  end

  assign vld   = vld_q;
  assign empty = empty_q;

endmodule

// File: rtl/sync_fwft_fifo.sv
module sync_fwft_fifo #(
  parameter int                   DATA_W   = 8,
  parameter int                   DEPTH    = 12,
  parameter bit                   AF_EN    = 1'b1,
  parameter int                   AF_LVL   = 9,
  parameter bit                   AE_EN    = 1'b1,
  parameter int                   AE_LVL   = 2,
  parameter sfifo_pkg::ram_mode_e RAM_MODE = sfifo_pkg::RAM_RBW,
  parameter bit                   RDY_RST  = 1'b1,
  localparam int                  AW       = sfifo_pkg::addr_bits(DEPTH),
  localparam int                  LVL_W    = sfifo_pkg::count_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_vld,
  output logic              in_rdy,
  output logic [DATA_W-1:0] out_data,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic              full,
  output logic              almost_full,
  output logic [LVL_W-1:0]  wr_level,
  output logic              empty,
  output logic              almost_empty,
  output logic [LVL_W-1:0]  rd_level
);

  localparam logic [LVL_W-1:0] CAP = LVL_W'(DEPTH);

  logic             rdy_q;
  logic             full_q;
  logic             wr_en;
  logic             wr_en_d1;
  logic             rd_en;
  logic             fetch;
  logic             vld_int;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [LVL_W-1:0] wl_nxt;
  logic [LVL_W-1:0] rl_nxt;
  logic [LVL_W-1:0] mem_lvl;
  logic [LVL_W-1:0] mem_nxt;
  logic             mem_flag;
  logic             rl_unused;

  // Handshakes
  assign wr_en = in_vld && rdy_q && !rst;
  assign rd_en = vld_int && out_rdy;

  // Storage and addressing
  sfifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MODE(RAM_MODE)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (in_data),
    .re    (fetch),
    .raddr (rd_ptr),
    .rdata (out_data)
  );

  sfifo_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk (clk), .rst (rst), .adv (wr_en), .ptr (wr_ptr)
  );

  sfifo_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk (clk), .rst (rst), .adv (fetch), .ptr (rd_ptr)
  );

  // Words in the array that have not yet moved to the read register
  sfifo_level #(.DEPTH(DEPTH), .LVL_W(LVL_W), .EN(1'b0), .THRESH(0), .ABOVE(1'b1)) u_mem_lvl (
    .clk (clk), .rst (rst), .inc (wr_en), .dec (fetch),
    .lvl (mem_lvl), .lvl_nxt (mem_nxt), .flag (mem_flag)
  );

  sfifo_ostage u_ostage (
    .clk       (clk),
    .rst       (rst),
    .mem_avail (mem_lvl != '0),
    .take      (out_rdy),
    .fetch     (fetch),
    .vld       (vld_int),
    .empty     (empty)
  );

  // Producer-side level: counts a word from its acceptance edge
  sfifo_level #(.DEPTH(DEPTH), .LVL_W(LVL_W), .EN(AF_EN), .THRESH(AF_LVL), .ABOVE(1'b1)) u_wr_lvl (
    .clk (clk), .rst (rst), .inc (wr_en), .dec (rd_en),
    .lvl (wr_level), .lvl_nxt (wl_nxt), .flag (almost_full)
  );

  // Consumer-side level: counts a word once it can be fetched
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_d1 <= 1'b0;
    end else begin
      wr_en_d1 <= wr_en;
    end
  end

  sfifo_level #(.DEPTH(DEPTH), .LVL_W(LVL_W), .EN(AE_EN), .THRESH(AE_LVL), .ABOVE(1'b0)) u_rd_lvl (
    .clk (clk), .rst (rst), .inc (wr_en_d1), .dec (rd_en),
    .lvl (rd_level), .lvl_nxt (rl_nxt), .flag (almost_empty)
  );

  // Registered full and ready, both derived from the next producer level
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      rdy_q  <= RDY_RST;
    end else begin
      full_q <= (wl_nxt == CAP);
      rdy_q  <= (wl_nxt != CAP);
    end
  end

  // Unused side outputs of the internal counters
  assign rl_unused = mem_flag ^ (^mem_nxt) ^ (^rl_nxt);

  assign in_rdy  = rdy_q;
  assign full    = full_q;
  assign out_vld = vld_int;

endmodule

// File: rtl/sync_fwft_fifo_chk.sv
module sync_fwft_fifo_chk #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 12,
  parameter bit AF_EN   = 1'b1,
  parameter int AF_LVL  = 9,
  parameter bit AE_EN   = 1'b1,
  parameter int AE_LVL  = 2,
  parameter bit RDY_RST = 1'b1,
  parameter int AW      = 4,
  parameter int LVL_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic              in_rdy,
  input logic [DATA_W-1:0] out_data,
  input logic              out_vld,
  input logic              out_rdy,
  input logic              full,
  input logic              almost_full,
  input logic [LVL_W-1:0]  wr_level,
  input logic              empty,
  input logic              almost_empty,
  input logic [LVL_W-1:0]  rd_level,
  input logic              wr_en,
  input logic              fetch,
  input logic [AW-1:0]     wr_ptr,
  input logic [AW-1:0]     rd_ptr
);

  localparam logic [LVL_W-1:0] CAP  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] AFT  = LVL_W'(AF_LVL);
  localparam logic [LVL_W-1:0] AET  = LVL_W'(AE_LVL);
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);

  // R1: a stalled word stays put
  p_hold_stall_r1: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));

  // R1: something to read means valid is up
  p_vld_level_r1: assert property (@(posedge clk) disable iff (rst)
    out_vld == (rd_level != '0));

  // R2: the slot being loaded into the read register is never written in the same cycle
  p_no_collide_r2: assert property (@(posedge clk) disable iff (rst)
    (fetch && wr_en) |-> (rd_ptr != wr_ptr));

  // R3: no input beat taken at capacity
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_level == CAP) |-> !in_rdy);

  // R3: an accepted beat with no read raises the producer level by one
  p_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_rdy && !(out_vld && out_rdy)) |=> (wr_level == $past(wr_level) + 1'b1));

  // R5
  p_full_r5: assert property (@(posedge clk) disable iff (rst)
    full == (wr_level == CAP));

  // R6
  p_lvl_order_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_level <= wr_level) && ((wr_level - rd_level) <= 1));

  p_empty_r6: assert property (@(posedge clk) disable iff (rst)
    empty == (rd_level == '0));

  // R7
  p_afull_r7: assert property (@(posedge clk) disable iff (rst)
    almost_full == (AF_EN && (wr_level >= AFT)));

  // R8
  p_aempty_r8: assert property (@(posedge clk) disable iff (rst)
    almost_empty == (AE_EN && (rd_level <= AET)));

  // R9: state after a reset edge
  p_rst_clear_r9: assert property (@(posedge clk)
    rst |=> (wr_level == '0 && rd_level == '0 && !out_vld && empty && !full));

  p_rst_rdy_r9: assert property (@(posedge clk)
    rst |=> (in_rdy == RDY_RST));

  // R10: addresses wrap at the last entry
  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_ptr == LAST)) |=> (wr_ptr == '0));

endmodule

bind sync_fwft_fifo sync_fwft_fifo_chk #(
  .DATA_W  (DATA_W),
  .DEPTH   (DEPTH),
  .AF_EN   (AF_EN),
  .AF_LVL  (AF_LVL),
  .AE_EN   (AE_EN),
  .AE_LVL  (AE_LVL),
  .RDY_RST (RDY_RST),
  .AW      (AW),
  .LVL_W   (LVL_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_vld       (in_vld),
  .in_rdy       (in_rdy),
  .out_data     (out_data),
  .out_vld      (out_vld),
  .out_rdy      (out_rdy),
  .full         (full),
  .almost_full  (almost_full),
  .wr_level     (wr_level),
  .empty        (empty),
  .almost_empty (almost_empty),
  .rd_level     (rd_level),
  .wr_en        (wr_en),
  .fetch        (fetch),
  .wr_ptr       (wr_ptr),
  .rd_ptr       (rd_ptr)
);

// File: tb/sync_fwft_fifo_bench.sv
module sync_fwft_fifo_bench;

  localparam int DW    = 8;
  localparam int DEPTH = 12;
  localparam int AFL   = 9;
  localparam int AEL   = 2;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic          in_vld = 1'b0;
  logic          out_rdy = 1'b0;

  // Instance A: read-before-write, ready high in reset, flags on
  logic          a_rdy, a_vld, a_full, a_af, a_empty, a_ae;
  logic [DW-1:0] a_data;
  logic [LW-1:0] a_wl, a_rl;
  // Instance B: write-before-read, ready low in reset, flags off
  logic          b_rdy, b_vld, b_full, b_af, b_empty, b_ae;
  logic [DW-1:0] b_data;
  logic [LW-1:0] b_wl, b_rl;

  always #2 clk = ~clk;  // 250 MHz

  sync_fwft_fifo #(
    .DATA_W(DW), .DEPTH(DEPTH), .AF_EN(1'b1), .AF_LVL(AFL), .AE_EN(1'b1), .AE_LVL(AEL),
    .RAM_MODE(sfifo_pkg::RAM_RBW), .RDY_RST(1'b1)
  ) u_sync_fwft_fifo (
    .clk(clk), .rst(rst), .in_data(in_data), .in_vld(in_vld), .in_rdy(a_rdy),
    .out_data(a_data), .out_vld(a_vld), .out_rdy(out_rdy), .full(a_full),
    .almost_full(a_af), .wr_level(a_wl), .empty(a_empty), .almost_empty(a_ae),
    .rd_level(a_rl)
  );

  sync_fwft_fifo #(
    .DATA_W(DW), .DEPTH(DEPTH), .AF_EN(1'b0), .AF_LVL(AFL), .AE_EN(1'b0), .AE_LVL(AEL),
    .RAM_MODE(sfifo_pkg::RAM_WBR), .RDY_RST(1'b0)
  ) u_sync_fwft_fifo_wbr (
    .clk(clk), .rst(rst), .in_data(in_data), .in_vld(in_vld), .in_rdy(b_rdy),
    .out_data(b_data), .out_vld(b_vld), .out_rdy(out_rdy), .full(b_full),
    .almost_full(b_af), .wr_level(b_wl), .empty(b_empty), .almost_empty(b_ae),
    .rd_level(b_rl)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model
  int q[$];
  bit pend     = 1'b0;  // a word was accepted at the previous edge
  bit rst_last = 1'b0;  // the previous edge was a reset edge

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rd_level();
    return q.size() - int'(pend);
  endfunction

  task automatic check_all();
    int wl  = q.size();
    int rl  = exp_rd_level();
    int vld = (rl > 0) ? 1 : 0;
    // Instance A
    chk("R5", "A wr_level", int'(a_wl), wl);
    chk("R6", "A rd_level", int'(a_rl), rl);
    chk("R1 R4", "A out_vld", int'(a_vld), vld);
    if (vld != 0) chk("R2 R10", "A out_data", int'(a_data), q[0]);
    chk("R5", "A full", int'(a_full), (wl == DEPTH) ? 1 : 0);
    chk("R6", "A empty", int'(a_empty), (rl == 0) ? 1 : 0);
    chk("R7", "A almost_full", int'(a_af), (wl >= AFL) ? 1 : 0);
    chk("R8", "A almost_empty", int'(a_ae), (rl <= AEL) ? 1 : 0);
    if (rst_last) chk("R9", "A in_rdy after reset", int'(a_rdy), 1);
    else          chk("R3", "A in_rdy", int'(a_rdy), (wl < DEPTH) ? 1 : 0);
    // Instance B
    chk("R5", "B wr_level", int'(b_wl), wl);
    chk("R6", "B rd_level", int'(b_rl), rl);
    chk("R1 R4", "B out_vld", int'(b_vld), vld);
    if (vld != 0) chk("R2 R10", "B out_data", int'(b_data), q[0]);
    chk("R5", "B full", int'(b_full), (wl == DEPTH) ? 1 : 0);
    chk("R6", "B empty", int'(b_empty), (rl == 0) ? 1 : 0);
    chk("R7", "B almost_full off", int'(b_af), 0);
    chk("R8", "B almost_empty off", int'(b_ae), 0);
    if (rst_last) chk("R9", "B in_rdy after reset", int'(b_rdy), 0);
    else          chk("R3", "B in_rdy", int'(b_rdy), (wl < DEPTH) ? 1 : 0);
  endtask

  // One clock: drive inputs, predict, advance, check away from the edge
  task automatic step(input bit v, input logic [DW-1:0] d, input bit rr, input bit r);
    bit wr;
    bit rd;
    if (rst_last) v = 1'b0;  // instances differ in ready for this one cycle
    in_vld  = v;
    in_data = d;
    out_rdy = rr;
    rst     = r;
    wr = v && !r && (q.size() < DEPTH);
    rd = !r && rr && (exp_rd_level() > 0);
    @(posedge clk);
    if (r) begin
      q.delete();
      pend     = 1'b0;
      rst_last = 1'b1;
    end else begin
      if (rd) void'(q.pop_front());
      if (wr) q.push_back(int'(d));
      pend     = wr;
      rst_last = 1'b0;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic run_rand(input int n, input int pv, input int pr);
    for (int i = 0; i < n; i++) begin
      step($urandom_range(99) < pv, DW'($urandom), $urandom_range(99) < pr, 1'b0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset with valid held high; nothing may be stored
    for (int i = 0; i < 3; i++) step(1'b1, DW'(8'hA0 + i), 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    // R4: a single word into an empty FIFO
    step(1'b1, 8'h5A, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    // R3 R5 R7: fill past capacity with the consumer stalled
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, DW'(i + 16), 1'b0, 1'b0);
    // R3: write and read offered together while full
    step(1'b1, 8'hEE, 1'b1, 1'b0);
    // R8: drain fully
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, '0, 1'b1, 1'b0);
    // R10: second fill and drain to wrap addresses again
    for (int i = 0; i < DEPTH; i++) step(1'b1, DW'(i + 64), 1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) step(1'b1, DW'(i + 96), 1'b1, 1'b0);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, '0, 1'b1, 1'b0);
    // R1 R2: random traffic with several mixes
    run_rand(1500, 50, 50);
    run_rand(1500, 90, 30);
    run_rand(1500, 30, 90);
    run_rand(1500, 100, 100);
    // R9: reset while partly filled and valid high
    for (int i = 0; i < 6; i++) step(1'b1, DW'(i + 200), 1'b0, 1'b0);
    step(1'b1, 8'h77, 1'b1, 1'b1);
    step(1'b1, 8'h78, 1'b1, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    run_rand(1500, 70, 60);
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, '0, 1'b1, 1'b0);
    finish_run();
  end

endmodule